// File: doc/BRIEF.md
# Truth-Table Programmed Bit-Slice ALU

This block is an N-bit arithmetic and logic unit made of identical one-bit slices. It has no opcode decoder. Three 4-bit truth-table codes choose the operation. Each slice holds three generic function units, and each unit is a 4-to-1 multiplexer:

- Its two input bits drive the mux select lines.
- Its 4-bit code supplies the mux data.
- It can therefore produce any Boolean function of its two inputs.

The three units in a slice have separate jobs:

- The propagate unit forms `P` from the two operand bits.
- The kill unit forms `K` from the same two operand bits.
- The result unit combines `P` with the carry arriving at that slice.

A carry cell in each slice forms the next carry from `P`, `K` and the incoming carry. The chain ripples from bit 0 to the most significant bit.

The same three codes are applied to every slice. One code set turns the datapath into an adder, another into a subtractor (the carry then behaves as a borrow), and others into an incrementer or any two-input bitwise function. The combinational datapath feeds a registered output stage, so the result and carry-out appear one clock after their inputs.

Top module: `tt_slice_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result_o` and `carry_o` become 0 after that edge.
- R2: A generic unit with first input x, second input y and code g outputs g[{x,y}]: bit 3 when both inputs are 1, bit 0 when both are 0. With `res_code_i` = 12, `result_o` bit i is therefore `prop_code_i`[{a_i[i], b_i[i]}] for all 16 propagate codes.
- R3: With prop/kill/result codes 6/1/6, `{carry_o, result_o}` equals `a_i + b_i + carry_in_i` (carry_in_i 0 gives a plain add).
- R4: With codes 9/4/9, `result_o` equals `a_i - b_i - carry_in_i` modulo 2^N. In this mode `carry_in_i` is a borrow-in, and `carry_o` is 1 exactly when `a_i < b_i + carry_in_i`.
- R5: With `res_code_i` = 12, the result is the propagate value and does not depend on `carry_in_i`. Propagate code 8 gives `a_i & b_i`, 14 gives `a_i | b_i` and 12 gives `a_i`.
- R6: With codes 12/3/6 and `carry_in_i` = 1, `result_o` equals `a_i + 1` modulo 2^N, and `carry_o` is 1 only when `a_i` is all ones.
- R7: Outputs change only at a rising clock edge, one cycle after the inputs that produce them. They hold while the inputs are held.
- R8: Operand corners wrap correctly: all ones plus 1 in add mode and 0 minus 1 in subtract mode both set `carry_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; output register updates on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| carry_in_i | input | 1 | Carry-in or borrow-in to bit 0 |
| prop_code_i | input | 4 | Truth table for the propagate unit |
| kill_code_i | input | 4 | Truth table for the kill unit |
| res_code_i | input | 4 | Truth table for the result unit |
| result_o | output | WIDTH | Registered result |
| carry_o | output | 1 | Registered carry/borrow out of the top slice |

## Verification
The assertions check, on every cycle, the outputs against the registered inputs for these modes:

- add,
- subtract with borrow,
- AND,
- OR,
- increment.

They also check that the outputs hold while the inputs are unchanged.

Only the bench's scenarios show the following:

- the reset value;
- the full decoding of all sixteen propagate codes;
- that the carry input is ignored when the propagate value is routed to the result;
- the one-cycle latency;
- the wrap cases at the operand extremes.

// File: rtl/tt_alu_pkg.sv
// Package: shared widths and the truth-table codes used by the ALU.
// Assumes code bit index = {first input, second input}.
package tt_alu_pkg;
    localparam int CODE_W = 4;
    typedef logic [CODE_W-1:0] tt_code_t;

    localparam tt_code_t TT_NOR      = 4'd1;   // ~x & ~y
    localparam tt_code_t TT_NOT_X    = 4'd3;   // ~x
    localparam tt_code_t TT_X_ANDN_Y = 4'd4;   // x & ~y
    localparam tt_code_t TT_XOR      = 4'd6;   // x ^ y
    localparam tt_code_t TT_AND      = 4'd8;   // x & y
    localparam tt_code_t TT_XNOR     = 4'd9;   // ~(x ^ y)
    localparam tt_code_t TT_PASS_X   = 4'd12;  // x
    localparam tt_code_t TT_OR       = 4'd14;  // x | y
endpackage

// File: rtl/tt_gen_unit.sv
// Generic function unit: a 4-to-1 mux whose select is {x, y} and whose
// data inputs are the 4-bit code, so any function of x and y is reachable.
// Assumes: purely combinational, no state.
module tt_gen_unit
    import tt_alu_pkg::*;
(
    input  tt_code_t code_i,
    input  logic     x_i,
    input  logic     y_i,
    output logic     f_o
);
    logic [1:0] sel;

    // Build the select index from the two data bits
    always_comb sel = {x_i, y_i};

    // Mux the selected truth-table bit out
    always_comb begin
        unique case (sel)
            2'b00:   f_o = code_i[0];
            2'b01:   f_o = code_i[1];
            2'b10:   f_o = code_i[2];
            default: f_o = code_i[3];
        endcase
    end
endmodule

// File: rtl/tt_carry_cell.sv
// Carry cell: next carry = (P & C) | (~P & ~K). Serves both carry and
// borrow, depending on how P and K were programmed.
// Assumes: purely combinational ripple element.
module tt_carry_cell (
    input  logic p_i,
    input  logic k_i,
    input  logic c_i,
    output logic c_o
);
    // Propagate the incoming carry, or generate when neither P nor K
    always_comb c_o = (p_i & c_i) | (~p_i & ~k_i);
endmodule

// File: rtl/tt_alu_slice.sv
// One bit of the ALU: propagate, kill and result generic units plus a
// carry cell. Assumes the codes are shared by every slice.
module tt_alu_slice
    import tt_alu_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     c_i,
    input  tt_code_t prop_code_i,
    input  tt_code_t kill_code_i,
    input  tt_code_t res_code_i,
    output logic     r_o,
    output logic     c_o
);
    logic p_bit;
    logic k_bit;

    tt_gen_unit u_prop (
        .code_i (prop_code_i),
        .x_i    (a_i),
        .y_i    (b_i),
        .f_o    (p_bit)
    );

    tt_gen_unit u_kill (
        .code_i (kill_code_i),
        .x_i    (a_i),
        .y_i    (b_i),
        .f_o    (k_bit)
    );

    tt_gen_unit u_res (
        .code_i (res_code_i),
        .x_i    (p_bit),
        .y_i    (c_i),
        .f_o    (r_o)
    );

    tt_carry_cell u_carry (
        .p_i (p_bit),
        .k_i (k_bit),
        .c_i (c_i),
        .c_o (c_o)
    );
endmodule

// File: rtl/tt_slice_alu.sv
// Top: WIDTH slices with a ripple carry from bit 0 upward, followed by a
// registered output stage with synchronous active-low reset.
// Assumes codes and operands are stable around the rising clock edge.
module tt_slice_alu
    import tt_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_in_i,
    input  tt_code_t         prop_code_i,
    input  tt_code_t         kill_code_i,
    input  tt_code_t         res_code_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    localparam int EXT_W = WIDTH + 1;

    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] res_comb;

    // Feed the external carry/borrow into bit 0
    always_comb chain[0] = carry_in_i;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
        tt_alu_slice u_slice (
            .a_i         (a_i[gi]),
            .b_i         (b_i[gi]),
            .c_i         (chain[gi]),
            .prop_code_i (prop_code_i),
            .kill_code_i (kill_code_i),
            .res_code_i  (res_code_i),
            .r_o         (res_comb[gi]),
            .c_o         (chain[gi+1])
        );
    end

    // Register result and top carry; clear on synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
        end else begin
            result_o <= res_comb;
            carry_o  <= chain[WIDTH];
        end
    end

    // R3
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_code_i == TT_XOR && kill_code_i == TT_NOR && res_code_i == TT_XOR)
        |=> ({carry_o, result_o} ==
             (EXT_W'($past(a_i)) + EXT_W'($past(b_i)) + EXT_W'($past(carry_in_i)))));

    // R4
    sub_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_code_i == TT_XNOR && kill_code_i == TT_X_ANDN_Y && res_code_i == TT_XNOR)
        |=> ((result_o == WIDTH'($past(a_i) - $past(b_i) - WIDTH'($past(carry_in_i)))) &&
             (carry_o == (EXT_W'($past(a_i)) <
                          (EXT_W'($past(b_i)) + EXT_W'($past(carry_in_i)))))));

    // R5
    and_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_code_i == TT_AND && res_code_i == TT_PASS_X)
        |=> (result_o == ($past(a_i) & $past(b_i))));

    // R5
    or_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_code_i == TT_OR && res_code_i == TT_PASS_X)
        |=> (result_o == ($past(a_i) | $past(b_i))));

    // R6
    incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_code_i == TT_PASS_X && kill_code_i == TT_NOT_X &&
         res_code_i == TT_XOR && carry_in_i)
        |=> ((result_o == WIDTH'($past(a_i) + 1'b1)) &&
             (carry_o == (&$past(a_i)))));

    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(a_i) && $stable(b_i) && $stable(carry_in_i) &&
         $stable(prop_code_i) && $stable(kill_code_i) && $stable(res_code_i))
        |=> ($stable(result_o) && $stable(carry_o)));
endmodule

// File: tb/tt_slice_alu_tb.sv
module tt_slice_alu_tb;
    localparam int N = 8;
    localparam int MASK = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a = '0, b = '0;
    logic         ci = 1'b0;
    logic [3:0]   gp = 4'd0, gk = 4'd0, gr = 4'd0;
    logic [N-1:0] res;
    logic         co;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    tt_slice_alu #(.WIDTH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .carry_in_i(ci),
        .prop_code_i(gp), .kill_code_i(gk), .res_code_i(gr),
        .result_o(res), .carry_o(co)
    );

    // Bitwise function of a truth-table code, per requirement R2
    function automatic int tt_apply(input logic [3:0] g, input int x, input int y);
        int r = 0;
        for (int i = 0; i < N; i++)
            if (g[{x[i], y[i]}]) r |= (1 << i);
        return r;
    endfunction

    task automatic check(input string req, input int exp_r, input int exp_c, input bit use_c);
        n_cmp++;
        if (int'(res) != exp_r || (use_c && int'(co) != exp_c)) begin
            n_bad++;
            $display("FAIL %s: res=%0h co=%0d expected res=%0h co=%0d",
                     req, res, co, exp_r, exp_c);
        end
    endtask

    // Drive on the falling edge, sample 1 ns after the next rising edge
    task automatic apply(input logic [3:0] p, input logic [3:0] k, input logic [3:0] r,
                         input int x, input int y, input bit c);
        @(negedge clk);
        gp = p; gk = k; gr = r; a = N'(x); b = N'(y); ci = c;
        @(posedge clk);
        #1;
    endtask

    task automatic do_add(input int x, input int y, input bit c, input string req);
        int s;
        apply(4'd6, 4'd1, 4'd6, x, y, c);
        s = x + y + int'(c);
        check(req, s & MASK, (s >> N) & 1, 1'b1);
    endtask

    task automatic do_sub(input int x, input int y, input bit c, input string req);
        apply(4'd9, 4'd4, 4'd9, x, y, c);
        check(req, (x - y - int'(c)) & MASK, (x < y + int'(c)) ? 1 : 0, 1'b1);
    endtask

    initial begin
        int x, y, snap;
        // R1: reset with non-zero stimulus
        gp = 4'd6; gk = 4'd1; gr = 4'd6; a = 8'hFF; b = 8'h01; ci = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 0, 0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: plain add and add-with-carry, random operands
        for (int i = 0; i < 40; i++) begin
            do_add(int'($urandom) & MASK, int'($urandom) & MASK, 1'b0, "R3");
            do_add(int'($urandom) & MASK, int'($urandom) & MASK, i[0], "R3");
        end
        // R4: subtract with and without borrow
        for (int i = 0; i < 40; i++) begin
            do_sub(int'($urandom) & MASK, int'($urandom) & MASK, 1'b0, "R4");
            do_sub(int'($urandom) & MASK, int'($urandom) & MASK, i[0], "R4");
        end
        // R8: corners
        do_add(MASK, 1, 1'b0, "R8");
        do_add(MASK, MASK, 1'b1, "R8");
        do_add(0, 0, 1'b0, "R8");
        do_sub(0, 1, 1'b0, "R8");
        do_sub(0, 0, 1'b1, "R8");
        do_sub(5, 5, 1'b0, "R8");

        // R2: every propagate code, result routed straight out
        for (int g = 0; g < 16; g++) begin
            for (int j = 0; j < 3; j++) begin
                x = int'($urandom) & MASK; y = int'($urandom) & MASK;
                apply(4'(g), 4'd0, 4'd12, x, y, 1'b0);
                check("R2", tt_apply(4'(g), x, y), 0, 1'b0);
            end
        end

        // R5: AND / OR / pass-A with the carry-in toggled both ways
        for (int i = 0; i < 20; i++) begin
            x = int'($urandom) & MASK; y = int'($urandom) & MASK;
            apply(4'd8, 4'd1, 4'd12, x, y, i[0]);
            check("R5", x & y, 0, 1'b0);
            apply(4'd14, 4'd1, 4'd12, x, y, ~i[0]);
            check("R5", x | y, 0, 1'b0);
            apply(4'd12, 4'd1, 4'd12, x, y, 1'b1);
            check("R5", x, 0, 1'b0);
            apply(4'd12, 4'd1, 4'd12, x, y, 1'b0);
            check("R5", x, 0, 1'b0);
        end

        // R6: increment, including the all-ones wrap
        for (int i = 0; i < 20; i++) begin
            x = (i == 0) ? MASK : (int'($urandom) & MASK);
            apply(4'd12, 4'd3, 4'd6, x, int'($urandom) & MASK, 1'b1);
            check("R6", (x + 1) & MASK, (x == MASK) ? 1 : 0, 1'b1);
        end

        // R7: one-cycle latency and hold while inputs are held
        do_add(8'h10, 8'h20, 1'b0, "R7");
        snap = int'(res);
        @(negedge clk);
        a = 8'h01; b = 8'h01;  // change inputs; output must not move yet
        #1;
        check("R7", snap, 0, 1'b1);
        @(posedge clk);
        #1;
        check("R7", 2, 0, 1'b1);
        repeat (3) begin
            @(posedge clk);
            #1;
            check("R7", 2, 0, 1'b1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule